// File: doc/BRIEF.md
# Configurable four-input logic cell

This block is one programmable logic cell of a fabric. A 16-entry truth table turns four data inputs into one combinational result. A fixed majority gate makes a carry for arithmetic chains. An optional register can capture the result. A static configuration vector sets the table contents and the mode bits. Routing between cells and the chaining of several cells are handled elsewhere.

Two LUT inputs can take special sources. Input 3 can take the cell's carry input, so that one cell can add a carry into its sum. Input 2 can take the cascade input, so that the result of a neighbouring cell can feed this table directly. The raw LUT result always has its own output, even when the register drives the cell output. The register powers up holding 0. Its reset can be asynchronous, or it can be synchronous, and in synchronous mode the clock enable gates the reset. The value that reset loads comes from the configuration.

Top module: `logic_cell`

## Requirements
- R1: `lut_out` equals `cfg[21:6][{I3,I2,I1,I0}]` combinationally. I3 is the most significant index bit and I0 comes from `din[0]`. The table occupies `cfg[21:6]`, with table entry 0 at `cfg[6]`.
- R2: When `cfg[4]` is 0, I3 is `din[3]`. When `cfg[4]` is 1, I3 is `carry_in`.
- R3: When `cfg[5]` is 0, I2 is `din[2]`. When `cfg[5]` is 1, I2 is `casc_in`. With table 0xF0F0 and `cfg[5]`=1, `lut_out` follows `casc_in`.
- R4: When `cfg[3]` is 1, `carry_out` is the majority of I1 (`din[1]`), I2 (after the R3 select) and `carry_in`.
- R5: When `cfg[3]` is 0, `carry_out` is 0 for every input pattern.
- R6: When `cfg[2]` is 0, `cell_out` equals `lut_out` combinationally. Clock, clock enable and reset have no effect on it.
- R7: When `cfg[2]` is 1, `cell_out` reads 0 before any clock edge or reset, whatever reset value (`cfg[0]`) is configured. This holds in both reset modes.
- R8: When `cfg[1]` is 1 (asynchronous mode), a high `rst` drives `cell_out` to `cfg[0]` without a clock edge, whatever `ce` is.
- R9: When `cfg[2]` is 1 and `rst` is low, a rising `clk` with `ce` high loads `lut_out` into the register. With `ce` low the register holds its value.
- R10: When `cfg[1]` is 0 (synchronous mode), a rising `clk` with `ce` and `rst` both high loads `cfg[0]`. With `ce` low the register holds, even if `rst` is high. A high `rst` changes nothing between clock edges.
- R11: When `cfg[2]` is 1, `lut_out` still follows the inputs combinationally, while `cell_out` changes only when the register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| ce | input | 1 | Register clock enable |
| rst | input | 1 | Register reset (synchronous or asynchronous, set by configuration) |
| din | input | 4 | General data inputs for I0 to I3 |
| carry_in | input | 1 | Carry from the previous cell; can also replace I3 |
| casc_in | input | 1 | Cascade input; can replace I2 |
| cfg | input | 22 | Static configuration: table in [21:6], I2 select [5], I3 select [4], carry enable [3], register enable [2], asynchronous mode [1], reset value [0] |
| lut_out | output | 1 | Combinational LUT result |
| carry_out | output | 1 | Gated majority carry |
| cell_out | output | 1 | Cell output, either the LUT result or the register |

## Verification
`lut_out` and `carry_out` are combinational, and so is `cell_out` when the register is off. Their results are due within the same cycle, so the bench drives inputs on the falling edge and samples one nanosecond later. Register loads and synchronous resets are due at the next rising edge. These are sampled one nanosecond after that edge, and the output is also sampled just before the edge, to confirm that nothing moved early. An asynchronous reset is due at once, so it is checked one nanosecond after `rst` rises, with no clock edge in between.

// File: rtl/lcell_pkg.sv
`timescale 1ns/1ps
package lcell_pkg;
    localparam int LUT_K  = 4;
    localparam int TBL_W  = 1 << LUT_K;

    typedef struct packed {
        logic [TBL_W-1:0] truth;
        logic             i2_from_casc;
        logic             i3_from_carry;
        logic             carry_en;
        logic             reg_en;
        logic             async_rst;
        logic             rst_val;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);

    typedef enum logic [1:0] {
        SRC_DIN   = 2'd0,
        SRC_CARRY = 2'd1,
        SRC_CASC  = 2'd2
    } in_src_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_RESET = 2'd2
    } ff_act_e;
endpackage

// File: rtl/lcell_inmux.sv
`timescale 1ns/1ps
module lcell_inmux
    import lcell_pkg::*;
#(
    parameter int K = LUT_K
) (
    input  logic [K-1:0] din,
    input  logic         carry_in,
    input  logic         casc_in,
    input  logic         sel_carry,
    input  logic         sel_casc,
    output logic [K-1:0] lut_in
);
    for (genvar g = 0; g < K; g++) begin : g_lane
        in_src_e src;
        if (g == K-1) begin : g_top
            assign src = sel_carry ? SRC_CARRY : SRC_DIN;
        end else if (g == K-2) begin : g_casc
            assign src = sel_casc ? SRC_CASC : SRC_DIN;
        end else begin : g_plain
            assign src = SRC_DIN;
        end

        always_comb begin
            unique case (src)
                SRC_CARRY: lut_in[g] = carry_in;
                SRC_CASC:  lut_in[g] = casc_in;
                default:   lut_in[g] = din[g];
            endcase
        end
    end
endmodule

// File: rtl/lcell_lut.sv
`timescale 1ns/1ps
module lcell_lut #(
    parameter int K = 4,
    localparam int W = 1 << K
) (
    input  logic [W-1:0] truth,
    input  logic [K-1:0] idx,
    output logic         y
);
    always_comb y = truth[idx];
endmodule

// File: rtl/lcell_carry.sv
`timescale 1ns/1ps
module lcell_carry (
    input  logic en,
    input  logic a,
    input  logic b,
    input  logic cin,
    output logic cout
);
    logic maj;
    always_comb begin
        maj  = (a & b) | (a & cin) | (b & cin);
        cout = en & maj;
    end
endmodule

// File: rtl/lcell_ff.sv
`timescale 1ns/1ps
module lcell_ff
    import lcell_pkg::*;
(
    input  logic clk,
    input  logic ce,
    input  logic rst,
    input  logic async_mode,
    input  logic rst_val,
    input  logic d,
    output logic q
);
    logic    q_async = 1'b0;
    logic    q_sync  = 1'b0;
    ff_act_e act_sync;

    // Asynchronous-reset register: reset wins at once, ignoring ce.
    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            q_async <= rst_val;
        else if (ce)
            q_async <= d;
    end

    // Synchronous-reset action decode: ce gates everything.
    always_comb begin
        unique case ({ce, rst})
            2'b10:   act_sync = ACT_LOAD;
            2'b11:   act_sync = ACT_RESET;
            default: act_sync = ACT_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        unique case (act_sync)
            ACT_LOAD:  q_sync <= d;
            ACT_RESET: q_sync <= rst_val;
            default:   q_sync <= q_sync;
        endcase
    end

    always_comb q = async_mode ? q_async : q_sync;
endmodule

// File: rtl/logic_cell.sv
`timescale 1ns/1ps
module logic_cell
    import lcell_pkg::*;
(
    input  logic             clk,
    input  logic             ce,
    input  logic             rst,
    input  logic [LUT_K-1:0] din,
    input  logic             carry_in,
    input  logic             casc_in,
    input  logic [CFG_W-1:0] cfg,
    output logic             lut_out,
    output logic             carry_out,
    output logic             cell_out
);
    cell_cfg_t        c;
    logic [LUT_K-1:0] lut_in;
    logic             ff_q;

    assign c = cfg;

    lcell_inmux #(.K(LUT_K)) u_inmux (
        .din       (din),
        .carry_in  (carry_in),
        .casc_in   (casc_in),
        .sel_carry (c.i3_from_carry),
        .sel_casc  (c.i2_from_casc),
        .lut_in    (lut_in)
    );

    lcell_lut #(.K(LUT_K)) u_lut (
        .truth (c.truth),
        .idx   (lut_in),
        .y     (lut_out)
    );

    lcell_carry u_carry (
        .en   (c.carry_en),
        .a    (lut_in[1]),
        .b    (lut_in[2]),
        .cin  (carry_in),
        .cout (carry_out)
    );

    lcell_ff u_ff (
        .clk        (clk),
        .ce         (ce),
        .rst        (rst),
        .async_mode (c.async_rst),
        .rst_val    (c.rst_val),
        .d          (lut_out),
        .q          (ff_q)
    );

    always_comb cell_out = c.reg_en ? ff_q : lut_out;
endmodule

// File: rtl/logic_cell_chk.sv
`timescale 1ns/1ps
module logic_cell_chk
    import lcell_pkg::*;
(
    input logic             clk,
    input logic             ce,
    input logic             rst,
    input logic [LUT_K-1:0] din,
    input logic             carry_in,
    input logic             casc_in,
    input logic [CFG_W-1:0] cfg,
    input logic             lut_out,
    input logic             carry_out,
    input logic             cell_out
);
    cell_cfg_t c;
    logic      i2m, i3m;
    assign c   = cfg;
    assign i2m = c.i2_from_casc  ? casc_in  : din[2];
    assign i3m = c.i3_from_carry ? carry_in : din[3];

    // R1 R2 R3: table lookup with the selected sources
    assert_lut_index_R1: assert property (@(posedge clk)
        lut_out == c.truth[{i3m, i2m, din[1], din[0]}]);

    // R4 R5: gated majority
    assert_carry_gate_R4: assert property (@(posedge clk)
        carry_out == (c.carry_en & ((din[1] & i2m) | (din[1] & carry_in) | (i2m & carry_in))));

    // R6: combinational path when register is off
    assert_comb_path_R6: assert property (@(posedge clk)
        !c.reg_en |-> cell_out == lut_out);

    // R8: asynchronous reset held with steady configuration
    assert_async_force_R8: assert property (@(posedge clk)
        (c.reg_en && c.async_rst && rst && $past(rst) && $stable(cfg)) |-> cell_out == c.rst_val);

    // R10: synchronous mode holds while ce is low
    assert_sync_hold_R10: assert property (@(posedge clk)
        (c.reg_en && !c.async_rst && !ce) |=> (!$stable(cfg) || $stable(cell_out)));
endmodule

bind logic_cell logic_cell_chk u_chk (
    .clk       (clk),
    .ce        (ce),
    .rst       (rst),
    .din       (din),
    .carry_in  (carry_in),
    .casc_in   (casc_in),
    .cfg       (cfg),
    .lut_out   (lut_out),
    .carry_out (carry_out),
    .cell_out  (cell_out)
);

// File: tb/logic_cell_tb.sv
`timescale 1ns/1ps
module logic_cell_tb;
    logic        clk = 1'b0;
    logic        ce = 1'b0;
    logic        rst = 1'b0;
    logic [3:0]  din = '0;
    logic        carry_in = 1'b0;
    logic        casc_in = 1'b0;
    logic [21:0] cfg = '0;
    logic        lut_out, carry_out, cell_out;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    logic_cell u_dut (
        .clk(clk), .ce(ce), .rst(rst), .din(din), .carry_in(carry_in),
        .casc_in(casc_in), .cfg(cfg), .lut_out(lut_out),
        .carry_out(carry_out), .cell_out(cell_out)
    );

    function automatic logic [21:0] mk(input logic [15:0] t, input logic s2, input logic s3,
                                       input logic cen, input logic ren, input logic ar,
                                       input logic rv);
        return {t, s2, s3, cen, ren, ar, rv};
    endfunction

    task automatic chk(input string req, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic t_powerup();
        cfg = mk(16'hFFFF, 0, 0, 0, 1, 0, 1);
        #1 chk("R7 sync mode power-up", cell_out, 1'b0);
        cfg = mk(16'hFFFF, 0, 0, 0, 1, 1, 1);
        #1 chk("R7 async mode power-up", cell_out, 1'b0);
    endtask

    task automatic t_lut_table();
        logic [15:0] tb_t = 16'h6A5C;
        @(negedge clk);
        cfg = mk(tb_t, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 16; i++) begin
            din = i[3:0];
            #1 chk("R1 table index", lut_out, tb_t[i]);
        end
        tb_t = 16'h8001;
        cfg = mk(tb_t, 0, 0, 0, 0, 0, 0);
        din = 4'hF; #1 chk("R1 top entry", lut_out, 1'b1);
        din = 4'h8; #1 chk("R1 I3 is MSB", lut_out, 1'b0);
    endtask

    task automatic t_i3_select();
        cfg = mk(16'hFF00, 0, 1, 0, 0, 0, 0);
        din = 4'b1000; carry_in = 0;
        #1 chk("R2 carry_in replaces I3 (0)", lut_out, 1'b0);
        din = 4'b0000; carry_in = 1;
        #1 chk("R2 carry_in replaces I3 (1)", lut_out, 1'b1);
        cfg = mk(16'hFF00, 0, 0, 0, 0, 0, 0);
        #1 chk("R2 din[3] used when select clear", lut_out, 1'b0);
    endtask

    task automatic t_i2_cascade();
        cfg = mk(16'hF0F0, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 16; i++) begin
            din = i[3:0]; casc_in = i[0] ^ i[2];
            #1 chk("R3 cascade pass-through", lut_out, i[0] ^ i[2]);
        end
        cfg = mk(16'hF0F0, 0, 0, 0, 0, 0, 0);
        din = 4'b0000; casc_in = 1;
        #1 chk("R3 din[2] used when select clear", lut_out, 1'b0);
        carry_in = 0; casc_in = 0;
    endtask

    task automatic t_carry();
        for (int i = 0; i < 8; i++) begin
            logic a = i[0], b = i[1], ci = i[2];
            cfg = mk(16'h0000, 0, 0, 1, 0, 0, 0);
            din = {1'b0, b, a, 1'b0}; carry_in = ci;
            #1 chk("R4 majority", carry_out, (a & b) | (a & ci) | (b & ci));
            cfg = mk(16'h0000, 0, 0, 0, 0, 0, 0);
            #1 chk("R5 carry disabled", carry_out, 1'b0);
        end
        cfg = mk(16'h0000, 1, 0, 1, 0, 0, 0);
        din = 4'b0010; casc_in = 1; carry_in = 0;
        #1 chk("R4 majority uses selected I2", carry_out, 1'b1);
        casc_in = 0; carry_in = 0;
    endtask

    task automatic t_comb_path();
        @(negedge clk);
        cfg = mk(16'hAAAA, 0, 0, 0, 0, 0, 1);
        ce = 1; rst = 1; din = 4'b0000;
        @(posedge clk); #1 chk("R6 comb out ignores reset/clock", cell_out, 1'b0);
        din = 4'b0001;
        #1 chk("R6 comb out follows LUT", cell_out, 1'b1);
        @(negedge clk); rst = 0; ce = 0;
    endtask

    task automatic t_sync_reg();
        @(negedge clk);
        cfg = mk(16'hFFFF, 0, 0, 0, 1, 0, 1);
        ce = 1; rst = 0;
        @(posedge clk); #1 chk("R9 load on enabled edge", cell_out, 1'b1);
        @(negedge clk);
        cfg = mk(16'h0000, 0, 0, 0, 1, 0, 0);
        ce = 0; rst = 1;
        #1 chk("R10 no change between edges", cell_out, 1'b1);
        @(posedge clk); #1 chk("R10 reset blocked by ce low", cell_out, 1'b1);
        @(negedge clk); ce = 1;
        @(posedge clk); #1 chk("R10 sync reset value", cell_out, 1'b0);
        @(negedge clk);
        rst = 0; cfg = mk(16'hFFFF, 0, 0, 0, 1, 0, 0);
        #1 chk("R11 lut_out live with register", lut_out, 1'b1);
        chk("R11 cell_out waits for edge", cell_out, 1'b0);
        @(posedge clk); #1 chk("R9 load after reset", cell_out, 1'b1);
        @(negedge clk); cfg = mk(16'h0000, 0, 0, 0, 1, 0, 0); ce = 0;
        @(posedge clk); #1 chk("R9 hold with ce low", cell_out, 1'b1);
    endtask

    task automatic t_async_reset();
        @(negedge clk);
        cfg = mk(16'h0000, 0, 0, 0, 1, 1, 1);
        ce = 0; rst = 1;
        #1 chk("R8 async set without edge", cell_out, 1'b1);
        @(negedge clk); rst = 0; ce = 1;
        @(posedge clk); #1 chk("R9 async mode load", cell_out, 1'b0);
        @(negedge clk); cfg = mk(16'hFFFF, 0, 0, 0, 1, 1, 0);
        @(posedge clk); #1 chk("R9 async mode load 1", cell_out, 1'b1);
        @(negedge clk); ce = 1; #1 rst = 1;
        #1 chk("R8 async clear without edge", cell_out, 1'b0);
        @(posedge clk); #1 chk("R8 held while reset high", cell_out, 1'b0);
        @(negedge clk); rst = 0; ce = 0;
        @(posedge clk); #1 chk("R9 async mode hold ce low", cell_out, 1'b0);
    endtask

    initial begin
        t_powerup();
        t_lut_table();
        t_i3_select();
        t_i2_cascade();
        t_carry();
        t_comb_path();
        t_sync_reg();
        t_async_reset();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        #80000;
        if (!done) begin
            done = 1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end
endmodule